// File: doc/BRIEF.md
# Supply Droop Code Converter for a Delay-Line Sensor

This block sits behind a delay-line time-to-digital converter that senses the supply voltage. Each clock it receives a thermometer-coded word. It reports how far that word has moved from a stored quiet-state reference. The measure is the number of bit positions that differ between the live word and the reference, computed as XOR followed by a population count. A stray bubble bit in the thermometer code adds one count and never corrupts the result. The count is pipelined so that one droop value leaves the block every clock at the sensor rate.

A baseline command latches the current sensor word or words as the reference. Software issues it while the current sink is idle. A trigger input opens a capture window that lasts a programmable number of output samples. The largest droop seen inside the window is held until the next trigger. An optional dual mode takes words from two sensors that run on phase-shifted clocks, alternating between them on successive valid samples. Each sensor has its own baseline, and a source flag marks every output.

Top module: `tdc_droop_conv`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs are zero after that edge. Both baselines clear to all zeros.
- R2: A sample presented with `samp_vld` high before clock edge k appears on `droop` with `droop_vld` high after edge k+2. Cycles with `samp_vld` low produce no `droop_vld`.
- R3: `droop` equals the number of 1 bits in (selected sensor word XOR that sensor's baseline). Every differing bit counts, including isolated bubble bits that are out of thermometer order.
- R4: When `cap_base` is high at an edge, that edge stores `code_a` as baseline A and `code_b` as baseline B. A sample taken at the same edge is still compared against the previous baseline.
- R5: With `dual_en` high, successive valid samples alternate between the two sensors, starting with sensor A. `droop_src` is 0 for sensor A and 1 for sensor B.
- R6: With `dual_en` low, every sample comes from `code_a` against baseline A, and `droop_src` is 0. The value on `code_b` has no effect on `droop`.
- R7: A trigger with a non-zero `win_len` clears `peak_val` to 0 and raises `win_busy`. The window then counts the next `win_len` outputs that have `droop_vld` high. `peak_val` becomes the maximum `droop` among those outputs.
- R8: After the last counted output, `win_busy` falls and `win_done` pulses high for one cycle. `peak_val` then holds, and later outputs do not change it.
- R9: A trigger during an open window restarts it: the peak clears and the count reloads. A trigger with `win_len` equal to 0 gives `win_done` high in the next cycle, with `win_busy` low and `peak_val` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sensor-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| code_a | input | CODE_W | Thermometer word from sensor A |
| code_b | input | CODE_W | Thermometer word from sensor B (dual mode only) |
| samp_vld | input | 1 | Sensor word valid this cycle |
| cap_base | input | 1 | Latch both sensor words as baselines |
| dual_en | input | 1 | Alternate samples between the two sensors |
| trig | input | 1 | Open a capture window |
| win_len | input | WIN_W | Window length in valid output samples |
| droop | output | $clog2(CODE_W+1) | Count of differing bits against the baseline |
| droop_vld | output | 1 | `droop` carries a sample |
| droop_src | output | 1 | Sensor that produced the sample (0 = A, 1 = B) |
| peak_val | output | $clog2(CODE_W+1) | Maximum droop in the current or last window |
| win_busy | output | 1 | Capture window open |
| win_done | output | 1 | One-cycle pulse when a window closes |

## Verification
The bench builds the block with its default values: a 64-bit sensor word, an 8-bit popcount group width (eight partial sums) and a 16-bit window length. Sixty-four bits give room for thermometer edges and bubble bits that fall in different popcount groups, so the cross-group sum is exercised. The short windows used (0, 2, 4 and 5 samples) reach the empty window, the restart and the close condition. Outputs that arrive after a window has closed are used to show that the held peak stays unchanged.

// File: rtl/tdc_droop_pkg.sv
package tdc_droop_pkg;
  typedef enum logic {SRC_A = 1'b0, SRC_B = 1'b1} src_e;

  function automatic int cnt_width(int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/tdc_base_sel.sv
// Baseline storage, sensor selection and the XOR stage.
module tdc_base_sel
  import tdc_droop_pkg::*;
#(
  parameter int CODE_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  input  logic              samp_vld,
  input  logic              cap_base,
  input  logic              dual_en,
  output logic [CODE_W-1:0] diff_q,
  output logic              vld_q,
  output src_e              src_q
);
  logic [CODE_W-1:0] base_a, base_b;
  logic              phase;
  logic              use_b;

  assign use_b = dual_en & phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_a <= '0;
      base_b <= '0;
      phase  <= 1'b0;
      diff_q <= '0;
      vld_q  <= 1'b0;
      src_q  <= SRC_A;
    end else begin
      if (cap_base) begin
        base_a <= code_a;
        base_b <= code_b;
      end
      if (!dual_en)      phase <= 1'b0;
      else if (samp_vld) phase <= ~phase;
      vld_q  <= samp_vld;
      src_q  <= use_b ? SRC_B : SRC_A;
      diff_q <= use_b ? (code_b ^ base_b) : (code_a ^ base_a);
    end
  end
endmodule

// File: rtl/tdc_popcnt.sv
// Two-stage population count: per-group partial sums, then a total.
module tdc_popcnt
  import tdc_droop_pkg::*;
#(
  parameter int CODE_W = 64,
  parameter int GRP_W  = 8,
  localparam int NGRP  = CODE_W / GRP_W,
  localparam int PW    = cnt_width(GRP_W),
  localparam int CW    = cnt_width(CODE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] diff,
  input  logic              in_vld,
  input  src_e              in_src,
  output logic [CW-1:0]     cnt_q,
  output logic              vld_q,
  output src_e              src_q
);
  logic [PW-1:0] part_q [NGRP];
  logic          vld_mid;
  src_e          src_mid;
  logic [CW-1:0] total;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [PW-1:0] pc;
    always_comb begin
      pc = '0;
      for (int i = 0; i < GRP_W; i++) pc = pc + PW'(diff[g*GRP_W + i]);
    end
    always_ff @(posedge clk) begin
      if (rst) part_q[g] <= '0;
      else     part_q[g] <= pc;
    end
  end

  always_comb begin
    total = '0;
    for (int g = 0; g < NGRP; g++) total = total + CW'(part_q[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_mid <= 1'b0;
      src_mid <= SRC_A;
      cnt_q   <= '0;
      vld_q   <= 1'b0;
      src_q   <= SRC_A;
    end else begin
      vld_mid <= in_vld;
      src_mid <= in_src;
      cnt_q   <= total;
      vld_q   <= vld_mid;
      src_q   <= src_mid;
    end
  end
endmodule

// File: rtl/tdc_peak_win.sv
// Trigger-started capture window with peak hold.
module tdc_peak_win #(
  parameter int CW    = 7,
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic [WIN_W-1:0] win_len,
  input  logic             s_vld,
  input  logic [CW-1:0]    s_cnt,
  output logic [CW-1:0]    peak_q,
  output logic             busy_q,
  output logic             done_q
);
  logic [WIN_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      peak_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      remain <= '0;
    end else begin
      done_q <= 1'b0;
      if (trig) begin
        peak_q <= '0;
        if (win_len == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          remain <= win_len;
        end
      end else if (busy_q && s_vld) begin
        if (s_cnt > peak_q) peak_q <= s_cnt;
        if (remain == WIN_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
        remain <= remain - WIN_W'(1);
      end
    end
  end
endmodule

// File: rtl/tdc_droop_conv.sv
module tdc_droop_conv
  import tdc_droop_pkg::*;
#(
  parameter int CODE_W = 64,
  parameter int GRP_W  = 8,
  parameter int WIN_W  = 16,
  localparam int CW    = cnt_width(CODE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  input  logic              samp_vld,
  input  logic              cap_base,
  input  logic              dual_en,
  input  logic              trig,
  input  logic [WIN_W-1:0]  win_len,
  output logic [CW-1:0]     droop,
  output logic              droop_vld,
  output logic              droop_src,
  output logic [CW-1:0]     peak_val,
  output logic              win_busy,
  output logic              win_done
);
  logic [CODE_W-1:0] diff;
  logic              diff_vld;
  src_e              diff_src;
  src_e              out_src;

  tdc_base_sel #(.CODE_W(CODE_W)) u_sel (
    .clk(clk), .rst(rst), .code_a(code_a), .code_b(code_b),
    .samp_vld(samp_vld), .cap_base(cap_base), .dual_en(dual_en),
    .diff_q(diff), .vld_q(diff_vld), .src_q(diff_src)
  );

  tdc_popcnt #(.CODE_W(CODE_W), .GRP_W(GRP_W)) u_pop (
    .clk(clk), .rst(rst), .diff(diff), .in_vld(diff_vld), .in_src(diff_src),
    .cnt_q(droop), .vld_q(droop_vld), .src_q(out_src)
  );

  assign droop_src = out_src;

  tdc_peak_win #(.CW(CW), .WIN_W(WIN_W)) u_win (
    .clk(clk), .rst(rst), .trig(trig), .win_len(win_len),
    .s_vld(droop_vld), .s_cnt(droop),
    .peak_q(peak_val), .busy_q(win_busy), .done_q(win_done)
  );
endmodule

// File: rtl/tdc_droop_chk.sv
module tdc_droop_chk #(
  parameter int CODE_W = 64,
  parameter int GRP_W  = 8,
  parameter int WIN_W  = 16,
  localparam int CW    = $clog2(CODE_W + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] code_a,
  input logic [CODE_W-1:0] code_b,
  input logic              samp_vld,
  input logic              cap_base,
  input logic              dual_en,
  input logic              trig,
  input logic [WIN_W-1:0]  win_len,
  input logic [CW-1:0]     droop,
  input logic              droop_vld,
  input logic              droop_src,
  input logic [CW-1:0]     peak_val,
  input logic              win_busy,
  input logic              win_done
);
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst)            age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R2: valid emerges three edges after the sample is taken
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (droop_vld == $past(samp_vld, 3)));

  // R3: the count never exceeds the word width
  a_r3_range: assert property (@(posedge clk) disable iff (rst)
    droop_vld |-> (droop <= CW'(CODE_W)));

  // R6: single-sensor samples always report sensor A
  a_r6_single_src: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && droop_vld && !$past(dual_en, 3)) |-> !droop_src);

  // R7: a non-empty trigger opens a window with a cleared peak
  a_r7_trig_clear: assert property (@(posedge clk) disable iff (rst)
    (trig && win_len != '0) |=> (win_busy && peak_val == '0));

  // R7: the peak covers every sample counted in the window
  a_r7_peak_ge: assert property (@(posedge clk) disable iff (rst)
    (win_busy && droop_vld && !trig) |=> (peak_val >= $past(droop)));

  // R8: the peak holds while no window is open
  a_r8_peak_hold: assert property (@(posedge clk) disable iff (rst)
    (!win_busy && !trig) |=> $stable(peak_val));
endmodule

bind tdc_droop_conv tdc_droop_chk #(.CODE_W(CODE_W), .GRP_W(GRP_W), .WIN_W(WIN_W)) u_chk (.*);

// File: tb/tdc_droop_conv_tb.sv
module tdc_droop_conv_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W = 64;
  localparam int WIN_W  = 16;
  localparam int CW     = $clog2(CODE_W + 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [CODE_W-1:0] code_a = '0, code_b = '0;
  logic              samp_vld = 1'b0, cap_base = 1'b0, dual_en = 1'b0, trig = 1'b0;
  logic [WIN_W-1:0]  win_len = '0;
  logic [CW-1:0]     droop, peak_val;
  logic              droop_vld, droop_src, win_busy, win_done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  int log_cnt [64];
  int log_src [64];
  int log_n = 0;
  int done_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdc_droop_conv #(.CODE_W(CODE_W), .GRP_W(8), .WIN_W(WIN_W)) u_dut (
    .clk(clk), .rst(rst), .code_a(code_a), .code_b(code_b), .samp_vld(samp_vld),
    .cap_base(cap_base), .dual_en(dual_en), .trig(trig), .win_len(win_len),
    .droop(droop), .droop_vld(droop_vld), .droop_src(droop_src),
    .peak_val(peak_val), .win_busy(win_busy), .win_done(win_done)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (droop_vld && log_n < 64) begin
        log_cnt[log_n] = int'(droop);
        log_src[log_n] = int'(droop_src);
        log_n = log_n + 1;
      end
      if (win_done) done_n = done_n + 1;
    end
  end

  function automatic logic [CODE_W-1:0] therm(int n);
    return (64'd1 << n) - 64'd1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    log_n = 0;
    done_n = 0;
  endtask

  task automatic push(logic [CODE_W-1:0] a, logic [CODE_W-1:0] b);
    code_a = a; code_b = b; samp_vld = 1'b1;
    @(negedge clk);
  endtask

  task automatic drain();
    samp_vld = 1'b0; cap_base = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic fire(int len);
    trig = 1'b1; win_len = WIN_W'(len);
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic finish_report();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // R1
  task automatic test_reset();
    chk("R1 droop", int'(droop), 0);
    chk("R1 droop_vld", int'(droop_vld), 0);
    chk("R1 peak_val", int'(peak_val), 0);
    chk("R1 win_busy", int'(win_busy), 0);
    chk("R1 win_done", int'(win_done), 0);
  endtask

  // R2
  task automatic test_latency();
    push(therm(6), '0);
    samp_vld = 1'b0;
    chk("R2 no valid after 1 edge", int'(droop_vld), 0);
    @(negedge clk);
    chk("R2 no valid after 2 edges", int'(droop_vld), 0);
    @(negedge clk);
    chk("R2 valid after 3 edges", int'(droop_vld), 1);
    chk("R2 value vs zero baseline", int'(droop), 6);
    @(negedge clk);
    chk("R2 single valid cycle", int'(droop_vld), 0);
    drain();
  endtask

  // R3, R4
  task automatic test_baseline();
    clear_log();
    cap_base = 1'b1;
    push(therm(20), therm(30));
    cap_base = 1'b0;
    push(therm(20), '0);
    push(therm(20) ^ 64'h0000_0100_0002_0008, '0);
    push(therm(50), '0);
    drain();
    chk("R4 sample count", log_n, 4);
    chk("R4 capture edge uses old baseline", log_cnt[0], 20);
    chk("R4 new baseline gives zero", log_cnt[1], 0);
    chk("R3 bubble bits across groups", log_cnt[2], 3);
    chk("R3 deep thermometer edge", log_cnt[3], 30);
  endtask

  // R5, R6
  task automatic test_dual_single();
    clear_log();
    dual_en = 1'b1;
    @(negedge clk);
    push(therm(25), therm(99 % 64));
    push(therm(2), therm(10));
    push(therm(20) ^ 64'h4, therm(5));
    push(therm(1), therm(30));
    drain();
    chk("R5 sample count", log_n, 4);
    chk("R5 first from A", log_src[0], 0);
    chk("R5 A count", log_cnt[0], 5);
    chk("R5 second from B", log_src[1], 1);
    chk("R5 B count", log_cnt[1], 20);
    chk("R5 third from A", log_src[2], 0);
    chk("R5 A bubble count", log_cnt[2], 1);
    chk("R5 fourth from B", log_src[3], 1);
    chk("R5 B at baseline", log_cnt[3], 0);
    dual_en = 1'b0;
    clear_log();
    @(negedge clk);
    push(therm(17), '1);
    push(therm(17), 64'hA5A5_5A5A_F0F0_0F0F);
    drain();
    chk("R6 sample count", log_n, 2);
    chk("R6 src A", log_src[0] + log_src[1], 0);
    chk("R6 code_b ignored 0", log_cnt[0], 3);
    chk("R6 code_b ignored 1", log_cnt[1], 3);
  endtask

  // R7, R8 (baseline A is therm(20))
  task automatic test_window();
    int d [7] = '{3, 9, 4, 7, 2, 15, 1};
    clear_log();
    fire(5);
    chk("R7 busy after trigger", int'(win_busy), 1);
    chk("R7 peak cleared", int'(peak_val), 0);
    for (int i = 0; i < 7; i++) push(therm(20 - d[i]), '0);
    drain();
    chk("R7 peak over window", int'(peak_val), 9);
    chk("R8 busy low after window", int'(win_busy), 0);
    chk("R8 one done pulse", done_n, 1);
    push(therm(0), '0);
    drain();
    chk("R8 peak holds after window", int'(peak_val), 9);
  endtask

  // R9
  task automatic test_retrig_zero();
    clear_log();
    fire(4);
    push(therm(8), '0);
    push(therm(9), '0);
    drain();
    chk("R9 still busy before retrigger", int'(win_busy), 1);
    fire(2);
    chk("R9 retrigger clears peak", int'(peak_val), 0);
    push(therm(15), '0);
    push(therm(14), '0);
    drain();
    chk("R9 peak of restarted window", int'(peak_val), 6);
    chk("R9 closed after restart", int'(win_busy), 0);
    chk("R9 only restarted window done", done_n, 1);
    trig = 1'b1; win_len = '0;
    @(negedge clk);
    trig = 1'b0;
    chk("R9 zero window done", int'(win_done), 1);
    chk("R9 zero window not busy", int'(win_busy), 0);
    chk("R9 zero window peak", int'(peak_val), 0);
    @(negedge clk);
    chk("R9 zero window done pulse ends", int'(win_done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst = 1'b0;
    @(negedge clk);
    test_latency();
    test_baseline();
    test_dual_single();
    test_window();
    test_retrig_zero();
    finish_report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_report();
    end
  end
endmodule